// File: doc/BRIEF.md
# LCD Segment Blink Masker

This block sits in the segment path of a multiplexed LCD driver. A word of segment data arrives for one common at a time, and the matching masked word leaves toward the output drivers. When blinking is enabled, a slow square wave derived from the frame tick picks the blanking half of each blink period. During that half the block clears a selected set of pixels: one pixel, segment 0 on every common, or the whole panel.

Configuration arrives on plain pins: a 2-bit scope select and a 3-bit rate select. The block samples both only on a frame tick, so the picture never changes scope or rate partway through a frame. The data path is a valid/ready stream with one register stage. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stops the producer at once and no beat is lost or duplicated.

Top module: `lcd_blink_masker`

## Requirements
- R1: With latched scope 0, every beat passes through unchanged, and the blink counter is held at zero, which is the visible phase.
- R2: With latched scope 1, during the blanking half only bit 0 of a beat whose `in_com` equals 0 is cleared. Beats with any other common pass unchanged.
- R3: With latched scope 2, during the blanking half bit 0 of every beat is cleared, whatever its common index.
- R4: With latched scope 3, during the blanking half the whole output word is zero.
- R5: A blink period lasts 8·2^r frame ticks for rate select r (0..7), giving divide ratios from 8 up to 1024. Counted from the tick that latches a nonzero scope while scope 0 was active, the first 4·2^r ticks are visible and the next 4·2^r are blanked.
- R6: Changes on `cfg_mode` and `cfg_rate` have no effect until a cycle in which `frame_tick` is high. In that cycle both fields are latched together.
- R7: `in_ready` is high exactly when the output register is empty or `out_ready` is high. A beat accepted on one clock edge appears on `out_seg`/`out_com` after that edge. While `out_valid` is high and `out_ready` is low, the output beat is held stable.
- R8: A beat accepted in the same cycle as a frame tick is masked with the blink state from before that tick. The new scope and phase apply to later beats.
- R9: In reset, `out_valid` is low, `in_ready` is high and the latched scope is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| cfg_mode | input | 2 | Blink scope: 0 none, 1 single pixel, 2 segment 0 on all commons, 3 all pixels |
| cfg_rate | input | 3 | Blink rate select r; period is 8·2^r frames |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat may be accepted |
| in_com | input | COM_W | Common index of the input beat |
| in_seg | input | SEG_W | Segment data for that common |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_com | output | COM_W | Common index carried with the beat |
| out_seg | output | SEG_W | Masked segment data |

## Verification
Two functions can land on the same clock edge: the frame tick, which latches new configuration and advances the blink phase, and the acceptance of a data beat. The bench provokes this by raising `frame_tick` and `in_valid` together on the tick that moves the phase from visible to blanked, and again on the tick that turns blinking on. It judges the result by requiring that the beat sent in that cycle is unmasked, while the next beat carries the new mask. Stalls are exercised separately by holding `out_ready` low while a second beat waits at the input.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;
  typedef enum logic [1:0] {
    SCOPE_NONE  = 2'd0,
    SCOPE_PIXEL = 2'd1,
    SCOPE_SEG0  = 2'd2,
    SCOPE_ALL   = 2'd3
  } blink_scope_e;

  localparam int RATE_W      = 3;
  localparam int MIN_DIV_LOG = 3;
endpackage

// File: rtl/lcdb_phase_gen.sv
module lcdb_phase_gen
  import lcdb_pkg::*;
#(
  parameter int RW      = RATE_W,
  parameter int DIV_LOG = MIN_DIV_LOG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  blink_scope_e  cfg_scope,
  input  logic [RW-1:0] cfg_rate,
  output blink_scope_e  act_scope,
  output logic [RW-1:0] act_rate,
  output logic          blank_on
);
  // the counter is wide enough for the slowest rate
  localparam int CNT_W = DIV_LOG + (1 << RW) - 1;
  localparam int IDX_W = $clog2(CNT_W);

  logic [CNT_W-1:0] frame_cnt;
  logic [IDX_W-1:0] phase_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_scope <= SCOPE_NONE;
      act_rate  <= '0;
      frame_cnt <= '0;
    end else begin
      if (frame_tick) begin
        act_scope <= cfg_scope;
        act_rate  <= cfg_rate;
      end
      if (act_scope == SCOPE_NONE)
        frame_cnt <= '0;
      else if (frame_tick)
        frame_cnt <= frame_cnt + 1'b1;
    end
  end

  // the half-period bit sits DIV_LOG-1 places above bit 0 for the fastest rate
  assign phase_idx = IDX_W'(DIV_LOG - 1) + IDX_W'(act_rate);
  assign blank_on  = (act_scope != SCOPE_NONE) && frame_cnt[phase_idx];
endmodule

// File: rtl/lcdb_mask_gen.sv
module lcdb_mask_gen
  import lcdb_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int COM_W = 3
) (
  input  logic             blank_on,
  input  blink_scope_e     scope,
  input  logic [COM_W-1:0] com,
  output logic [SEG_W-1:0] clear_mask
);
  logic first_hit;

  always_comb begin
    unique case (scope)
      SCOPE_PIXEL: first_hit = (com == '0);
      SCOPE_SEG0:  first_hit = 1'b1;
      SCOPE_ALL:   first_hit = 1'b1;
      default:     first_hit = 1'b0;
    endcase
  end

  for (genvar b = 0; b < SEG_W; b++) begin : g_bit
    if (b == 0) begin : g_first
      assign clear_mask[b] = blank_on && first_hit;
    end else begin : g_rest
      assign clear_mask[b] = blank_on && (scope == SCOPE_ALL);
    end
  end
endmodule

// File: rtl/lcdb_stream_reg.sv
module lcdb_stream_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end
endmodule

// File: rtl/lcd_blink_masker.sv
module lcd_blink_masker
  import lcdb_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int COM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [1:0]       cfg_mode,
  input  logic [2:0]       cfg_rate,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [COM_W-1:0] in_com,
  input  logic [SEG_W-1:0] in_seg,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [COM_W-1:0] out_com,
  output logic [SEG_W-1:0] out_seg
);
  localparam int PAY_W = SEG_W + COM_W;

  blink_scope_e     act_scope;
  logic [2:0]       act_rate;
  logic             blank_on;
  logic [SEG_W-1:0] clear_mask;
  logic [PAY_W-1:0] pay_in, pay_out;

  lcdb_phase_gen #(.RW(3), .DIV_LOG(MIN_DIV_LOG)) phase_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .cfg_scope  (blink_scope_e'(cfg_mode)),
    .cfg_rate   (cfg_rate),
    .act_scope  (act_scope),
    .act_rate   (act_rate),
    .blank_on   (blank_on)
  );

  lcdb_mask_gen #(.SEG_W(SEG_W), .COM_W(COM_W)) mask_i (
    .blank_on   (blank_on),
    .scope      (act_scope),
    .com        (in_com),
    .clear_mask (clear_mask)
  );

  assign pay_in = {in_com, in_seg & ~clear_mask};

  lcdb_stream_reg #(.W(PAY_W)) stage_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pay_in),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pay_out)
  );

  assign out_com = pay_out[PAY_W-1 -: COM_W];
  assign out_seg = pay_out[SEG_W-1:0];
endmodule

// File: rtl/lcdb_checker.sv
module lcdb_checker #(
  parameter int SEG_W = 32,
  parameter int COM_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_tick,
  input logic             in_valid,
  input logic             in_ready,
  input logic [COM_W-1:0] in_com,
  input logic [SEG_W-1:0] in_seg,
  input logic             out_valid,
  input logic             out_ready,
  input logic [COM_W-1:0] out_com,
  input logic [SEG_W-1:0] out_seg,
  input logic [1:0]       act_mode,
  input logic [2:0]       act_rate,
  input logic             blank_on
);
  logic take;
  assign take = in_valid && in_ready;

  assert_visible_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == 2'd0) |-> !blank_on);

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !blank_on) |=> (out_seg == $past(in_seg)));

  assert_pixel_other_com_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && blank_on && act_mode == 2'd1 && in_com != '0) |=> (out_seg == $past(in_seg)));

  assert_pixel_com0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && blank_on && act_mode == 2'd1 && in_com == '0)
      |=> (out_seg == ($past(in_seg) & ~SEG_W'(1))));

  assert_seg0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && blank_on && act_mode == 2'd2) |=> (out_seg == ($past(in_seg) & ~SEG_W'(1))));

  assert_all_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && blank_on && act_mode == 2'd3) |=> (out_seg == '0));

  assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(act_mode) && $stable(act_rate)));

  assert_take_shows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_valid && out_com == $past(in_com)));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_seg) && $stable(out_com)));
endmodule

bind lcd_blink_masker lcdb_checker #(.SEG_W(SEG_W), .COM_W(COM_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_tick (frame_tick),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_com     (in_com),
  .in_seg     (in_seg),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_com    (out_com),
  .out_seg    (out_seg),
  .act_mode   (act_scope),
  .act_rate   (act_rate),
  .blank_on   (blank_on)
);

// File: tb/lcd_blink_masker_tb.sv
`timescale 1ns/1ps
module lcd_blink_masker_tb_top;
  localparam int SEG_W = 32;
  localparam int COM_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_tick = 1'b0;
  logic [1:0]       cfg_mode = 2'd0;
  logic [2:0]       cfg_rate = 3'd0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [COM_W-1:0] in_com = '0;
  logic [SEG_W-1:0] in_seg = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [COM_W-1:0] out_com;
  logic [SEG_W-1:0] out_seg;

  int errs = 0;
  int checks = 0;
  int m_mode = 0, m_rate = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  lcd_blink_masker #(.SEG_W(SEG_W), .COM_W(COM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .cfg_mode(cfg_mode), .cfg_rate(cfg_rate),
    .in_valid(in_valid), .in_ready(in_ready), .in_com(in_com), .in_seg(in_seg),
    .out_valid(out_valid), .out_ready(out_ready), .out_com(out_com), .out_seg(out_seg)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SEG_W-1:0] model(input int com, input logic [SEG_W-1:0] d);
    bit blank;
    blank = (m_mode != 0) && (((m_cnt >> (2 + m_rate)) & 1) == 1);
    if (!blank) return d;
    case (m_mode)
      1: return (com == 0) ? (d & ~SEG_W'(1)) : d;
      2: return d & ~SEG_W'(1);
      default: return '0;
    endcase
  endfunction

  task automatic model_tick(input int nm, input int nr);
    if (m_mode == 0) m_cnt = 0;
    else m_cnt = (m_cnt + 1) % 1024;
    m_mode = nm;
    m_rate = nr;
  endtask

  task automatic do_tick(input int nm, input int nr);
    @(negedge clk);
    cfg_mode = 2'(nm); cfg_rate = 3'(nr); frame_tick = 1'b1;
    @(posedge clk); #1;
    frame_tick = 1'b0;
    model_tick(nm, nr);
  endtask

  task automatic send(input string req, input int com, input logic [SEG_W-1:0] d);
    logic [SEG_W-1:0] exp;
    @(negedge clk);
    in_valid = 1'b1; in_com = COM_W'(com); in_seg = d;
    exp = model(com, d);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " com"}, 64'(out_com), 64'(com));
    check(req, 64'(out_seg), 64'(exp));
  endtask

  initial begin
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [SEG_W-1:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 out_valid in reset", 64'(out_valid), 64'd0);
    check("R9 in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // R9/R1: scope 0 after reset passes data
    send("R9 R1 passthrough after reset", 0, 32'hDEAD_BEEF);
    send("R1 passthrough", 5, 32'h0000_0001);

    // R1: scope 0 latched on many ticks, never blanks
    for (int k = 0; k < 40; k++) begin
      do_tick(0, k % 8);
      send("R1 scope0 over ticks", k % 8, 32'hFFFF_FFFF ^ (SEG_W'(k) << 3));
    end

    // R6: config changed without a tick has no effect
    @(negedge clk); cfg_mode = 2'd3; cfg_rate = 3'd0;
    repeat (12) @(negedge clk);
    send("R6 cfg ignored without tick", 0, 32'h1234_5679);

    // R5 with R2/R3/R4: sweep every scope and rate through a full period
    for (int m = 1; m <= 3; m++) begin
      for (int r = 0; r < 8; r++) begin
        do_tick(0, 0);
        do_tick(m, r);
        for (int k = 0; k < (8 << r) + 2; k++) begin
          d = 32'hF0F0_0001 ^ (SEG_W'(k) << 4);
          send($sformatf("R5 R%0d rate%0d tick%0d com0", m + 1, r, k), 0, d);
          send($sformatf("R5 R%0d rate%0d tick%0d comN", m + 1, r, k), 1 + (k % 7), d);
          do_tick(m, r);
        end
      end
    end

    // R1: returning to scope 0 restarts at the visible phase
    do_tick(3, 0); do_tick(3, 0); do_tick(3, 0); do_tick(3, 0); do_tick(3, 0);
    do_tick(0, 0);
    send("R1 scope0 resets phase", 2, 32'hAAAA_5555);
    do_tick(3, 0);
    send("R1 visible after re-enable", 3, 32'h5555_AAAB);

    // R8: beat and phase-flipping tick in the same cycle
    do_tick(0, 0); do_tick(3, 0);
    do_tick(3, 0); do_tick(3, 0); do_tick(3, 0);
    @(negedge clk);
    in_valid = 1'b1; in_com = 3'd2; in_seg = 32'hCAFE_F00D;
    cfg_mode = 2'd3; cfg_rate = 3'd0; frame_tick = 1'b1;
    d = model(2, 32'hCAFE_F00D);
    @(posedge clk); #1;
    in_valid = 1'b0; frame_tick = 1'b0;
    model_tick(3, 0);
    @(negedge clk);
    check("R8 same-cycle beat uses old phase", 64'(out_seg), 64'(d));
    check("R8 old phase was visible", 64'(out_seg), 64'h0000_0000_CAFE_F00D);
    send("R8 next beat blanked", 2, 32'hCAFE_F00D);

    // R8: scope enabled in the same cycle as a beat
    do_tick(0, 0);
    @(negedge clk);
    in_valid = 1'b1; in_com = 3'd0; in_seg = 32'h0F0F_0F0F;
    cfg_mode = 2'd3; frame_tick = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; frame_tick = 1'b0;
    model_tick(3, 0);
    @(negedge clk);
    check("R8 enable tick beat unmasked", 64'(out_seg), 64'h0000_0000_0F0F_0F0F);

    // R7: back-pressure
    do_tick(0, 0);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_com = 3'd1; in_seg = 32'h1111_1111;
    @(posedge clk); #1;
    in_com = 3'd4; in_seg = 32'h2222_2222;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 stalled in_ready low", 64'(in_ready), 64'd0);
      check("R7 stalled out held", 64'(out_seg), 64'h0000_0000_1111_1111);
      check("R7 stalled com held", 64'(out_com), 64'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R7 drain lets input in", 64'(in_ready), 64'd1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 second beat after drain", 64'(out_seg), 64'h0000_0000_2222_2222);
    check("R7 second beat com", 64'(out_com), 64'd4);
    @(negedge clk);
    check("R7 empty after drain", 64'(out_valid), 64'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule